// File: doc/BRIEF.md
# Interrupt Completion and Deactivation Controller

This block sits in the CPU-facing side of an interrupt controller and retires interrupts that software has finished handling. It keeps a per-interrupt active flag and two active-priority bit vectors, one per interrupt group, with one bit per preemption level. An acknowledge path outside this block reports each newly taken interrupt on a small activation port. That port marks the interrupt active and records its preemption level.

Software retires an interrupt in one of two ways. A completion write (EOI) always releases the highest active preemption level. In combined mode it also clears the interrupt's active flag. In split mode, clearing the active flag is left to a separate deactivate write (DIR). Both writes check the group of the target interrupt against the security attribute of the access. A non-secure access that names a group 0 interrupt has no effect. A deactivate write issued while split mode is off is an error. The block drops that write and raises a one-cycle error pulse.

The running priority is held in a register. It is recomputed after every change to the active-priority vectors.

Top module: `eoi_dir_ctrl`

## Requirements
- R1: After reset, `active_o`, `apr_grp0_o` and `apr_grp1_o` are all zero, `run_prio_o` is 0x100 (idle) and `guest_err_o` is 0.
- R2: An activation for interrupt N at level L sets bit N of `active_o`. It also sets bit L of `apr_grp1_o` when bit N of `irq_group_i` is 1 (1 = group 1), and bit L of `apr_grp0_o` when that bit is 0.
- R3: An accepted EOI finds the lowest level index L that is set in either vector. It clears bit L of `apr_grp1_o` if the target is group 1 and that bit is set there; otherwise it clears bit L of `apr_grp0_o`. If neither vector has a bit set, nothing changes.
- R4: `run_prio_o` equals eight times the lowest set level index across both vectors, or 0x100 when both vectors are zero. It is valid in the cycle after the change.
- R5: An accepted EOI with `cfg_split_i` = 0 also clears the target's bit in `active_o`. With `cfg_split_i` = 1, an EOI leaves `active_o` unchanged.
- R6: An accepted DIR with `cfg_split_i` = 1 clears only the target's bit in `active_o`. Both active-priority vectors stay unchanged.
- R7: An in-range DIR while `cfg_split_i` = 0 changes no state. It raises `guest_err_o` for exactly the following cycle.
- R8: An EOI or DIR whose `wr_id_i` is 32 or more (at or above the implemented count) changes no state and raises no error.
- R9: With security enabled, an EOI or DIR that has `wr_nonsecure_i` = 1 and targets a group 0 interrupt changes no state. The same write to a group 1 interrupt takes effect.
- R10: With security disabled (HAS_SECURITY = 0), `wr_nonsecure_i` has no effect and every write is handled as secure.
- R11: The error check comes before the security check. A non-secure in-range DIR to a group 0 interrupt with `cfg_split_i` = 0 still raises `guest_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_split_i | input | 1 | 1 = split priority drop and deactivation |
| irq_group_i | input | 32 | Group of each interrupt, 1 = group 1 |
| act_valid_i | input | 1 | Activation strobe from the acknowledge path |
| act_id_i | input | 5 | Interrupt being activated |
| act_level_i | input | 5 | Preemption level of the activated interrupt |
| eoi_valid_i | input | 1 | Completion write strobe |
| dir_valid_i | input | 1 | Deactivate write strobe (an EOI in the same cycle takes precedence) |
| wr_id_i | input | 10 | Interrupt ID carried by the write |
| wr_nonsecure_i | input | 1 | Security attribute of the write, 1 = non-secure |
| active_o | output | 32 | Active flag per interrupt |
| apr_grp0_o | output | 32 | Group 0 active-priority vector, one bit per level |
| apr_grp1_o | output | 32 | Group 1 active-priority vector, one bit per level |
| run_prio_o | output | 9 | Running priority, 0x100 when idle |
| guest_err_o | output | 1 | One-cycle pulse on a misused deactivate |

## Verification
The hardest case to reach is a priority drop in which the lowest active level belongs to the other group's vector. In that case the EOI either clears a bit in group 0 on behalf of a group 1 interrupt, or clears nothing. The stimulus reaches it by pairing every target with a second interrupt of the opposite group, activated at a level either above or below the target's. Each pair is swept across split mode, access security, group, write kind and in-range and out-of-range IDs. Two copies of the block, one with security and one without, receive the same stimulus. This shows the effect of the security attribute directly.

// File: rtl/eoi_pkg.sv
package eoi_pkg;

   // Decoded effect of one software write on the interrupt state
   typedef struct packed {
      logic drop;       // release one active-priority level
      logic clr_active; // clear the target's active flag
      logic flag_err;   // misused deactivate
      logic grp1;       // target belongs to group 1
   } eoi_action_t;

   // Write kinds seen by the filter
   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_EOI  = 2'd1,
      WR_DIR  = 2'd2
   } wr_kind_e;

endpackage

// File: rtl/eoi_lsb_find.sv
module eoi_lsb_find #(
   parameter int W = 32
) (
   input  logic [W-1:0]         vec_i,
   output logic                 found_o,
   output logic [$clog2(W)-1:0] idx_o
);
   localparam int IW = $clog2(W);

   initial begin
      if (W < 2) $error("eoi_lsb_find: W must be at least 2");
   end

   // Scan from the top so the lowest set index wins
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/eoi_req_filter.sv
module eoi_req_filter
   import eoi_pkg::*;
#(
   parameter int NIRQ         = 32,
   parameter int ID_W         = 10,
   parameter bit HAS_SECURITY = 1'b1
) (
   input  logic                     eoi_valid_i,
   input  logic                     dir_valid_i,
   input  logic [ID_W-1:0]          wr_id_i,
   input  logic                     wr_nonsecure_i,
   input  logic                     split_i,
   input  logic [NIRQ-1:0]          irq_group_i,
   output eoi_action_t              action_o,
   output logic [$clog2(NIRQ)-1:0]  idx_o
);
   localparam int IDX_W = $clog2(NIRQ);

   initial begin
      if (NIRQ >= (1 << ID_W)) $error("eoi_req_filter: ID width too small for NIRQ");
   end

   logic     in_range;
   logic     tgt_grp1;
   logic     ns_eff;
   logic     sec_block;
   wr_kind_e kind;

   assign in_range = (wr_id_i < ID_W'(NIRQ));
   assign idx_o    = wr_id_i[IDX_W-1:0];
   assign tgt_grp1 = in_range & irq_group_i[idx_o];

   generate
      if (HAS_SECURITY) begin : g_sec
         assign ns_eff = wr_nonsecure_i;
      end else begin : g_nosec
         // Without security every access is treated as secure
         assign ns_eff = 1'b0;
      end
   endgenerate

   assign sec_block = ns_eff & ~tgt_grp1;

   always_comb begin
      if (eoi_valid_i)      kind = WR_EOI;
      else if (dir_valid_i) kind = WR_DIR;
      else                  kind = WR_NONE;
   end

   always_comb begin
      action_o      = '0;
      action_o.grp1 = tgt_grp1;
      unique case (kind)
         WR_EOI: begin
            if (in_range && !sec_block) begin
               action_o.drop       = 1'b1;
               action_o.clr_active = ~split_i;
            end
         end
         WR_DIR: begin
            // Order: range, then mode, then security
            if (in_range) begin
               if (!split_i)        action_o.flag_err   = 1'b1;
               else if (!sec_block) action_o.clr_active = 1'b1;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/eoi_active_bits.sv
module eoi_active_bits #(
   parameter int NIRQ = 32
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    set_i,
   input  logic [$clog2(NIRQ)-1:0] set_idx_i,
   input  logic                    clr_i,
   input  logic [$clog2(NIRQ)-1:0] clr_idx_i,
   output logic [NIRQ-1:0]         active_o
);
   logic [NIRQ-1:0] act_q;
   logic [NIRQ-1:0] act_d;

   always_comb begin
      act_d = act_q;
      if (clr_i) act_d[clr_idx_i] = 1'b0;
      if (set_i) act_d[set_idx_i] = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) act_q <= '0;
      else         act_q <= act_d;
   end

   assign active_o = act_q;

   logic seen_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) seen_q <= 1'b0;
      else         seen_q <= 1'b1;
   end

   AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && !set_i && !clr_i |=> $stable(active_o)); // R5

endmodule

// File: rtl/eoi_apr_unit.sv
module eoi_apr_unit #(
   parameter int LEVELS = 32,
   parameter int PRIO_W = 8
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      act_valid_i,
   input  logic [$clog2(LEVELS)-1:0] act_level_i,
   input  logic                      act_grp1_i,
   input  logic                      drop_i,
   input  logic                      drop_grp1_i,
   output logic [LEVELS-1:0]         apr0_o,
   output logic [LEVELS-1:0]         apr1_o,
   output logic [PRIO_W:0]           run_prio_o
);
   localparam int LW    = $clog2(LEVELS);
   localparam int SHIFT = PRIO_W - LW;
   localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

   initial begin
      if (SHIFT < 0) $error("eoi_apr_unit: more levels than priority values");
   end

   logic [LEVELS-1:0] apr0_q, apr1_q, apr0_d, apr1_d;
   logic [PRIO_W:0]   prio_q, prio_d;
   logic              cur_found, nxt_found;
   logic [LW-1:0]     cur_idx, nxt_idx;
   logic [PRIO_W-1:0] nxt_prio_val;

   eoi_lsb_find #(.W(LEVELS)) i_cur_find (
      .vec_i   (apr0_q | apr1_q),
      .found_o (cur_found),
      .idx_o   (cur_idx)
   );

   always_comb begin
      apr0_d = apr0_q;
      apr1_d = apr1_q;
      if (drop_i && cur_found) begin
         if (drop_grp1_i && apr1_q[cur_idx]) apr1_d[cur_idx] = 1'b0;
         else                                apr0_d[cur_idx] = 1'b0;
      end
      if (act_valid_i) begin
         if (act_grp1_i) apr1_d[act_level_i] = 1'b1;
         else            apr0_d[act_level_i] = 1'b1;
      end
   end

   eoi_lsb_find #(.W(LEVELS)) i_nxt_find (
      .vec_i   (apr0_d | apr1_d),
      .found_o (nxt_found),
      .idx_o   (nxt_idx)
   );

   generate
      if (SHIFT > 0) begin : g_scaled
         assign nxt_prio_val = {nxt_idx, {SHIFT{1'b0}}};
      end else begin : g_direct
         assign nxt_prio_val = nxt_idx;
      end
   endgenerate

   assign prio_d = nxt_found ? {1'b0, nxt_prio_val} : IDLE;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         apr0_q <= '0;
         apr1_q <= '0;
         prio_q <= IDLE;
      end else begin
         apr0_q <= apr0_d;
         apr1_q <= apr1_d;
         prio_q <= prio_d;
      end
   end

   assign apr0_o     = apr0_q;
   assign apr1_o     = apr1_q;
   assign run_prio_o = prio_q;

   logic seen_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) seen_q <= 1'b0;
      else         seen_q <= 1'b1;
   end

   AST_APR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && !drop_i && !act_valid_i |=> $stable(apr0_o) && $stable(apr1_o)); // R6

   AST_IDLE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (apr0_o == '0 && apr1_o == '0) |-> run_prio_o == IDLE); // R4

   AST_DROP_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && drop_i && !act_valid_i |=>
         $countones({apr1_o, apr0_o}) <= $past($countones({apr1_o, apr0_o}))); // R3

endmodule

// File: rtl/eoi_dir_ctrl.sv
module eoi_dir_ctrl
   import eoi_pkg::*;
#(
   parameter int NIRQ         = 32,
   parameter int ID_W         = 10,
   parameter int LEVELS       = 32,
   parameter int PRIO_W       = 8,
   parameter bit HAS_SECURITY = 1'b1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      cfg_split_i,
   input  logic [NIRQ-1:0]           irq_group_i,
   input  logic                      act_valid_i,
   input  logic [$clog2(NIRQ)-1:0]   act_id_i,
   input  logic [$clog2(LEVELS)-1:0] act_level_i,
   input  logic                      eoi_valid_i,
   input  logic                      dir_valid_i,
   input  logic [ID_W-1:0]           wr_id_i,
   input  logic                      wr_nonsecure_i,
   output logic [NIRQ-1:0]           active_o,
   output logic [LEVELS-1:0]         apr_grp0_o,
   output logic [LEVELS-1:0]         apr_grp1_o,
   output logic [PRIO_W:0]           run_prio_o,
   output logic                      guest_err_o
);
   localparam int IDX_W = $clog2(NIRQ);

   eoi_action_t      action;
   logic [IDX_W-1:0] tgt_idx;
   logic             err_q;

   eoi_req_filter #(
      .NIRQ         (NIRQ),
      .ID_W         (ID_W),
      .HAS_SECURITY (HAS_SECURITY)
   ) i_filter (
      .eoi_valid_i    (eoi_valid_i),
      .dir_valid_i    (dir_valid_i),
      .wr_id_i        (wr_id_i),
      .wr_nonsecure_i (wr_nonsecure_i),
      .split_i        (cfg_split_i),
      .irq_group_i    (irq_group_i),
      .action_o       (action),
      .idx_o          (tgt_idx)
   );

   eoi_active_bits #(.NIRQ(NIRQ)) i_active (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (act_valid_i),
      .set_idx_i (act_id_i),
      .clr_i     (action.clr_active),
      .clr_idx_i (tgt_idx),
      .active_o  (active_o)
   );

   eoi_apr_unit #(.LEVELS(LEVELS), .PRIO_W(PRIO_W)) i_apr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .act_valid_i (act_valid_i),
      .act_level_i (act_level_i),
      .act_grp1_i  (irq_group_i[act_id_i]),
      .drop_i      (action.drop),
      .drop_grp1_i (action.grp1),
      .apr0_o      (apr_grp0_o),
      .apr1_o      (apr_grp1_o),
      .run_prio_o  (run_prio_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) err_q <= 1'b0;
      else         err_q <= action.flag_err;
   end

   assign guest_err_o = err_q;

   logic seen_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) seen_q <= 1'b0;
      else         seen_q <= 1'b1;
   end

   AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && guest_err_o |->
         $past(dir_valid_i && !eoi_valid_i && !cfg_split_i && (wr_id_i < ID_W'(NIRQ)))); // R7

   AST_SPLIT_KEEPS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && eoi_valid_i && cfg_split_i && !act_valid_i |=> active_o == $past(active_o)); // R5

   generate
      if (HAS_SECURITY) begin : g_sec_chk
         AST_NS_GRP0_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            seen_q && (eoi_valid_i || dir_valid_i) && wr_nonsecure_i && !act_valid_i &&
            (wr_id_i < ID_W'(NIRQ)) && !irq_group_i[wr_id_i[IDX_W-1:0]] |=>
               $stable(active_o) && $stable(apr_grp0_o) && $stable(apr_grp1_o)); // R9
      end
   endgenerate

endmodule

// File: tb/test_eoi_dir_ctrl.sv
`timescale 1ns/1ps
module test_eoi_dir_ctrl;
   localparam int CLK_P  = 10;
   localparam int NIRQ   = 32;
   localparam int ID_W   = 10;
   localparam int LEVELS = 32;
   localparam int PRIO_W = 8;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             split;
   logic [NIRQ-1:0]  grp;
   logic             act_v;
   logic [4:0]       act_id;
   logic [4:0]       act_lv;
   logic             eoi_v, dir_v, ns;
   logic [ID_W-1:0]  wid;

   logic [31:0] act_a, a0_a, a1_a, act_b, a0_b, a1_b;
   logic [8:0]  pr_a, pr_b;
   logic        err_a, err_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Models: index 0 = with security, 1 = without
   logic [31:0] m_act [2];
   logic [31:0] m_a0  [2];
   logic [31:0] m_a1  [2];
   logic        m_err [2];

   always #(CLK_P/2) clk = ~clk;

   eoi_dir_ctrl #(.NIRQ(NIRQ), .ID_W(ID_W), .LEVELS(LEVELS), .PRIO_W(PRIO_W),
                  .HAS_SECURITY(1'b1)) i_eoi_dir_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .cfg_split_i(split), .irq_group_i(grp),
      .act_valid_i(act_v), .act_id_i(act_id), .act_level_i(act_lv),
      .eoi_valid_i(eoi_v), .dir_valid_i(dir_v), .wr_id_i(wid), .wr_nonsecure_i(ns),
      .active_o(act_a), .apr_grp0_o(a0_a), .apr_grp1_o(a1_a),
      .run_prio_o(pr_a), .guest_err_o(err_a));

   eoi_dir_ctrl #(.NIRQ(NIRQ), .ID_W(ID_W), .LEVELS(LEVELS), .PRIO_W(PRIO_W),
                  .HAS_SECURITY(1'b0)) i_eoi_dir_ctrl_nosec (
      .clk_i(clk), .rst_ni(rst_n), .cfg_split_i(split), .irq_group_i(grp),
      .act_valid_i(act_v), .act_id_i(act_id), .act_level_i(act_lv),
      .eoi_valid_i(eoi_v), .dir_valid_i(dir_v), .wr_id_i(wid), .wr_nonsecure_i(ns),
      .active_o(act_b), .apr_grp0_o(a0_b), .apr_grp1_o(a1_b),
      .run_prio_o(pr_b), .guest_err_o(err_b));

   function automatic logic [8:0] exp_prio(input logic [31:0] v);
      logic [8:0] r = 9'h100;
      for (int i = 31; i >= 0; i--) if (v[i]) r = 9'(i * 8);
      return r;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] actual, input logic [31:0] expected);
      checks++;
      if (actual !== expected) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
      end
   endtask

   task automatic check_all(input string req, input string req_b);
      chk(req,   "A active", act_a, m_act[0]);
      chk(req,   "A apr0",   a0_a,  m_a0[0]);
      chk(req,   "A apr1",   a1_a,  m_a1[0]);
      chk("R4",  "A prio",   32'(pr_a), 32'(exp_prio(m_a0[0] | m_a1[0])));
      chk(req,   "A err",    32'(err_a), 32'(m_err[0]));
      chk(req_b, "B active", act_b, m_act[1]);
      chk(req_b, "B apr0",   a0_b,  m_a0[1]);
      chk(req_b, "B apr1",   a1_b,  m_a1[1]);
      chk("R4",  "B prio",   32'(pr_b), 32'(exp_prio(m_a0[1] | m_a1[1])));
      chk(req_b, "B err",    32'(err_b), 32'(m_err[1]));
   endtask

   task automatic tick();
      @(posedge clk);
      #(CLK_P/4);
   endtask

   task automatic idle_inputs();
      act_v = 0; eoi_v = 0; dir_v = 0; ns = 0; wid = '0; act_id = '0; act_lv = '0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      idle_inputs();
      tick(); tick();
      rst_n = 1;
      for (int k = 0; k < 2; k++) begin
         m_act[k] = '0; m_a0[k] = '0; m_a1[k] = '0; m_err[k] = 0;
      end
   endtask

   task automatic activate(input int id, input int lv);
      act_v = 1; act_id = 5'(id); act_lv = 5'(lv);
      tick();
      act_v = 0;
      for (int k = 0; k < 2; k++) begin
         m_act[k][id] = 1'b1;
         if (grp[id]) m_a1[k][lv] = 1'b1;
         else         m_a0[k][lv] = 1'b1;
         m_err[k] = 0;
      end
      check_all("R2", "R2");
   endtask

   task automatic write(input bit is_eoi, input int id, input bit nsv);
      bit    inr, g, blk;
      int    low;
      string ra, rb;
      eoi_v = is_eoi; dir_v = !is_eoi; wid = ID_W'(id); ns = nsv;
      tick();
      eoi_v = 0; dir_v = 0; ns = 0;
      inr = (id < NIRQ);
      g   = inr ? grp[id] : 1'b0;
      for (int k = 0; k < 2; k++) begin
         blk = (k == 0) && nsv && !g;
         m_err[k] = 0;
         if (is_eoi) begin
            if (inr && !blk) begin
               low = -1;
               for (int i = 31; i >= 0; i--) if (m_a0[k][i] | m_a1[k][i]) low = i;
               if (low >= 0) begin
                  if (g && m_a1[k][low]) m_a1[k][low] = 1'b0;
                  else                   m_a0[k][low] = 1'b0;
               end
               if (!split) m_act[k][id] = 1'b0;
            end
         end else if (inr) begin
            if (!split)    m_err[k] = 1;
            else if (!blk) m_act[k][id] = 1'b0;
         end
      end
      if (!inr)                              ra = "R8";
      else if (!is_eoi && !split && nsv && !g) ra = "R11";
      else if (!is_eoi && !split)             ra = "R7";
      else if (nsv && !g)                     ra = "R9";
      else if (is_eoi && split)               ra = "R5";
      else if (is_eoi)                        ra = "R3";
      else                                    ra = "R6";
      rb = (nsv && !g && inr) ? "R10" : ra;
      check_all(ra, rb);
      tick();
      m_err[0] = 0; m_err[1] = 0;
      chk("R7", "A err cleared", 32'(err_a), 32'd0);
      chk("R7", "B err cleared", 32'(err_b), 32'd0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int ids [5] = '{0, 5, 31, 32, 1023};
      split = 0;
      grp   = '0;
      do_reset();
      check_all("R1", "R1");
      for (int sp = 0; sp < 2; sp++)
      for (int nsel = 0; nsel < 2; nsel++)
      for (int gs = 0; gs < 2; gs++)
      for (int op = 0; op < 2; op++)
      for (int is = 0; is < 5; is++)
      for (int lvs = 0; lvs < 2; lvs++) begin
         int id = ids[is];
         int x  = (id < NIRQ) ? id : 7;
         int y  = (x + 3) % NIRQ;
         do_reset();
         split = sp[0];
         grp   = {NIRQ{~gs[0]}};
         grp[x] = gs[0];
         activate(y, lvs ? 4 : 12);
         activate(x, 9);
         write(op == 0, id, nsel[0]);
         // a completion followed by a deactivate of the same interrupt
         if (op == 0) write(1'b0, id, nsel[0]);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule